// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block lets a host reach external byte-wide or word-wide memory over sixteen shared pins. Each access begins with an address phase, in which the address latch strobe is high and the pins carry address. It continues with a setup phase, a read or write strobe phase and a hold phase. In those later phases the pins carry data, or a mix of data and the remaining address byte. Byte mode uses a 24-bit address and word mode uses a 16-bit address. The length of every phase is set by its own input.

The host side is a single-request port. A request is taken when the engine is idle. A one-cycle ready pulse marks the end of the access, and read data is valid during that pulse. A flag-mode input hands the same pins to sixteen general-purpose flags. In flag mode the two byte halves are swapped, and each pin is driven only when its direction bit is set.

Top module: `admux_master`

## Requirements
- R1: A request (req_i high while idle and flag mode off) is accepted at a rising edge. ready_o is high for exactly one cycle, the cycle after the hold phase ends. rdata_o holds the read result in that cycle.
- R2: The four phases run in order: address, setup, strobe, hold. Each lasts its t_*_i value in cycles, and a value of 0 counts as 1. ale_o is high only in the address phase. The strobe never starts in the same cycle that ale_o falls.
- R3: For a read, rd_o is high during the strobe phase and nowhere else. For a write, wr_o is high during the strobe phase and nowhere else.
- R4: Byte mode (wide_i=0), address phase: pins 7:0 carry address 15:8 and pins 15:8 carry address 23:16.
- R5: Byte mode write, setup/strobe/hold: pins 7:0 carry write data 7:0 and pins 15:8 carry address 7:0.
- R6: Word mode (wide_i=1), address phase: pins 15:0 carry address 15:0.
- R7: Word mode write, setup/strobe/hold: pins 15:0 carry write data 15:0.
- R8: All sixteen pins are driven in the address phase and for the whole of a write. After the address phase of a read, a byte-mode read drives only pins 15:8 (ad_oe_o=16'hFF00), and a word-mode read drives no pin.
- R9: Read data is taken from the pins at the edge that ends the last strobe cycle. A byte read returns {8'h00, pins 7:0}.
- R10: In flag mode (flag_en_i=1 while idle), pin p<8 outputs flag p+8 and pin p>=8 outputs flag p-8. Each pin is enabled by the direction bit of its flag.
- R11: flag_in_o is always the pins with the halves swapped: flag f<8 reads pin f+8, and flag f>=8 reads pin f-8.
- R12: While flag_en_i is high, requests are ignored: no ale_o, no strobe and no ready_o.
- R13: When idle and not in flag mode, no pin is driven and ale_o, rd_o and wr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = word mode, 0 = byte mode |
| addr_i | input | 24 | Access address |
| wdata_i | input | 16 | Write data |
| t_ale_i | input | 4 | Address phase length |
| t_setup_i | input | 4 | Setup phase length |
| t_strobe_i | input | 4 | Strobe phase length |
| t_hold_i | input | 4 | Hold phase length |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data |
| flag_en_i | input | 1 | Pins act as flags |
| flag_out_i | input | 16 | Flag output values |
| flag_dir_i | input | 16 | Flag direction, 1 = output |
| flag_in_o | output | 16 | Flag input values |
| ad_i | input | 16 | Pin input values |
| ad_o | output | 16 | Pin output values |
| ad_oe_o | output | 16 | Per-pin output enable |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |

## Verification
The request is accepted at the first rising edge that sees it. ale_o rises just after that edge, and each later phase begins t cycles after the one before it. ready_o comes one cycle after the last hold cycle, so a complete access takes the sum of the four lengths plus one cycle before ready. The flag pins and flag_in_o respond in the same cycle as their inputs. The bench steps its own phase model at each rising edge. It drives all inputs and compares every output at the falling edge, half a cycle after each register update, so each expected value is already due when it is sampled.

// File: rtl/admux_pkg.sv
package admux_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/admux_seq.sv
module admux_seq
  import admux_pkg::*;
#(
  parameter int TCNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TCNT_W-1:0] t_ale_i,
  input  logic [TCNT_W-1:0] t_setup_i,
  input  logic [TCNT_W-1:0] t_strobe_i,
  input  logic [TCNT_W-1:0] t_hold_i,
  output phase_e            phase_o,
  output logic              last_o,
  output logic              ready_o
);
  phase_e            ph_q;
  logic [TCNT_W-1:0] cnt_q;
  logic              ready_q;

  // remaining-cycles reload; zero length is treated as one cycle
  function automatic logic [TCNT_W-1:0] span(input logic [TCNT_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (start_i) begin
          ph_q  <= PH_ALE;
          cnt_q <= span(t_ale_i);
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        case (ph_q)
          PH_ALE:    begin ph_q <= PH_SETUP;  cnt_q <= span(t_setup_i);  end
          PH_SETUP:  begin ph_q <= PH_STROBE; cnt_q <= span(t_strobe_i); end
          PH_STROBE: begin ph_q <= PH_HOLD;   cnt_q <= span(t_hold_i);   end
          default:   begin ph_q <= PH_IDLE;   ready_q <= 1'b1;           end
        endcase
      end
    end
  end

  assign phase_o = ph_q;
  assign last_o  = (ph_q != PH_IDLE) && (cnt_q == '0);
  assign ready_o = ready_q;

  // R1
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);
endmodule

// File: rtl/admux_pinmux.sv
module admux_pinmux
  import admux_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  phase_e                phase_i,
  input  logic                  wide_i,
  input  logic                  we_i,
  input  logic [3*BYTE_W-1:0]   addr_i,
  input  logic [2*BYTE_W-1:0]   wdata_i,
  output logic [2*BYTE_W-1:0]   ad_o,
  output logic [2*BYTE_W-1:0]   ad_oe_o,
  output logic                  ale_o,
  output logic                  rd_o,
  output logic                  wr_o
);
  localparam int AD_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] a_lo, a_mid, a_hi;
  assign a_lo  = addr_i[BYTE_W-1:0];
  assign a_mid = addr_i[2*BYTE_W-1:BYTE_W];
  assign a_hi  = addr_i[3*BYTE_W-1:2*BYTE_W];

  always_comb begin
    ale_o   = 1'b0;
    rd_o    = 1'b0;
    wr_o    = 1'b0;
    ad_o    = '0;
    ad_oe_o = '0;
    case (phase_i)
      PH_IDLE: ;
      PH_ALE: begin
        ale_o   = 1'b1;
        ad_oe_o = '1;
        ad_o    = wide_i ? {a_mid, a_lo} : {a_hi, a_mid};
      end
      default: begin
        rd_o = (phase_i == PH_STROBE) && !we_i;
        wr_o = (phase_i == PH_STROBE) && we_i;
        if (we_i) begin
          ad_oe_o = '1;
          ad_o    = wide_i ? wdata_i : {a_lo, wdata_i[BYTE_W-1:0]};
        end else if (!wide_i) begin
          // byte read: upper half keeps the low address byte
          ad_oe_o = {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
          ad_o    = {a_lo, {BYTE_W{1'b0}}};
        end else begin
          ad_oe_o = {AD_W{1'b0}};
        end
      end
    endcase
  end
endmodule

// File: rtl/admux_flagmap.sv
module admux_flagmap #(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] flag_out_i,
  input  logic [2*BYTE_W-1:0] flag_dir_i,
  input  logic [2*BYTE_W-1:0] pin_i,
  output logic [2*BYTE_W-1:0] pin_o,
  output logic [2*BYTE_W-1:0] pin_oe_o,
  output logic [2*BYTE_W-1:0] flag_in_o
);
  for (genvar p = 0; p < 2 * BYTE_W; p++) begin : g_pin
    localparam int F = (p < BYTE_W) ? p + BYTE_W : p - BYTE_W;
    assign pin_o[p]     = flag_out_i[F];
    assign pin_oe_o[p]  = flag_dir_i[F];
    assign flag_in_o[F] = pin_i[p];
  end
endmodule

// File: rtl/admux_master.sv
module admux_master
  import admux_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int TCNT_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                wide_i,
  input  logic [3*BYTE_W-1:0] addr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic [TCNT_W-1:0]   t_ale_i,
  input  logic [TCNT_W-1:0]   t_setup_i,
  input  logic [TCNT_W-1:0]   t_strobe_i,
  input  logic [TCNT_W-1:0]   t_hold_i,
  output logic                ready_o,
  output logic [2*BYTE_W-1:0] rdata_o,
  input  logic                flag_en_i,
  input  logic [2*BYTE_W-1:0] flag_out_i,
  input  logic [2*BYTE_W-1:0] flag_dir_i,
  output logic [2*BYTE_W-1:0] flag_in_o,
  input  logic [2*BYTE_W-1:0] ad_i,
  output logic [2*BYTE_W-1:0] ad_o,
  output logic [2*BYTE_W-1:0] ad_oe_o,
  output logic                ale_o,
  output logic                rd_o,
  output logic                wr_o
);
  localparam int AD_W   = 2 * BYTE_W;
  localparam int ADDR_W = 3 * BYTE_W;

  phase_e            phase;
  logic              last, start, idle, flag_act;
  logic              we_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [AD_W-1:0]   wdata_q, rdata_q;
  logic [AD_W-1:0]   bus_ad, bus_oe, flg_ad, flg_oe;

  assign idle     = (phase == PH_IDLE);
  assign start    = idle && req_i && !flag_en_i;
  assign flag_act = idle && flag_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= we_i;
      wide_q  <= wide_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      rdata_q <= '0;
    else if (phase == PH_STROBE && last && !we_q)
      rdata_q <= wide_q ? ad_i : {{BYTE_W{1'b0}}, ad_i[BYTE_W-1:0]};
  end

  admux_seq #(.TCNT_W(TCNT_W)) seq_i (
    .clk_i, .rst_ni, .start_i(start),
    .t_ale_i, .t_setup_i, .t_strobe_i, .t_hold_i,
    .phase_o(phase), .last_o(last), .ready_o
  );

  admux_pinmux #(.BYTE_W(BYTE_W)) pinmux_i (
    .phase_i(phase), .wide_i(wide_q), .we_i(we_q),
    .addr_i(addr_q), .wdata_i(wdata_q),
    .ad_o(bus_ad), .ad_oe_o(bus_oe), .ale_o, .rd_o, .wr_o
  );

  admux_flagmap #(.BYTE_W(BYTE_W)) flagmap_i (
    .flag_out_i, .flag_dir_i, .pin_i(ad_i),
    .pin_o(flg_ad), .pin_oe_o(flg_oe), .flag_in_o
  );

  assign ad_o    = flag_act ? flg_ad : bus_ad;
  assign ad_oe_o = flag_act ? flg_oe : bus_oe;
  assign rdata_o = rdata_q;

  // R12
  ale_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |-> $past(req_i && !flag_en_i));
  // R2
  setup_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> !rd_o && !wr_o);
  // R2
  strobe_after_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_o) || $rose(wr_o)) |-> $past(!ale_o));
  // R8
  read_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (ad_oe_o[BYTE_W-1:0] == '0));
endmodule

// File: tb/admux_master_tb.sv
module admux_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [3:0]  t_a = 4'd1, t_s = 4'd1, t_t = 4'd1, t_h = 4'd1;
  logic        flag_en = 1'b0;
  logic [15:0] flag_out = '0, flag_dir = '0, ad_in = '0;
  logic        ready, ale, rd, wr;
  logic [15:0] rdata, flag_in, ad_out, ad_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  admux_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata),
    .t_ale_i(t_a), .t_setup_i(t_s), .t_strobe_i(t_t), .t_hold_i(t_h),
    .ready_o(ready), .rdata_o(rdata),
    .flag_en_i(flag_en), .flag_out_i(flag_out), .flag_dir_i(flag_dir),
    .flag_in_o(flag_in), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .ale_o(ale), .rd_o(rd), .wr_o(wr)
  );

  // reference model: phase 0 idle, 1 addr, 2 setup, 3 strobe, 4 hold
  int          m_ph, m_left;
  bit          m_rdy, m_we, m_wide;
  logic [23:0] m_addr;
  logic [15:0] m_wdata, m_rdata;

  function automatic int len(input logic [3:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_rdy = 0; m_we = 0; m_wide = 0;
      m_addr = '0; m_wdata = '0; m_rdata = '0;
    end else begin
      m_rdy = 0;
      if (m_ph == 0) begin
        if (req && !flag_en) begin
          m_we = we; m_wide = wide; m_addr = addr; m_wdata = wdata;
          m_ph = 1; m_left = len(t_a);
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_ph == 3 && !m_we) m_rdata = m_wide ? ad_in : {8'h00, ad_in[7:0]};
          case (m_ph)
            1: begin m_ph = 2; m_left = len(t_s); end
            2: begin m_ph = 3; m_left = len(t_t); end
            3: begin m_ph = 4; m_left = len(t_h); end
            default: begin m_ph = 0; m_rdy = 1; end
          endcase
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit          fl;
    logic [15:0] e_ad, e_oe;
    fl = flag_en && (m_ph == 0);
    e_ad = '0; e_oe = '0;
    if (fl) begin
      e_ad = {flag_out[7:0], flag_out[15:8]};
      e_oe = {flag_dir[7:0], flag_dir[15:8]};
    end else if (m_ph == 1) begin
      e_oe = 16'hFFFF;
      e_ad = m_wide ? m_addr[15:0] : m_addr[23:8];
    end else if (m_ph != 0) begin
      if (m_we) begin
        e_oe = 16'hFFFF;
        e_ad = m_wide ? m_wdata : {m_addr[7:0], m_wdata[7:0]};
      end else if (!m_wide) begin
        e_oe = 16'hFF00;
        e_ad = {m_addr[7:0], 8'h00};
      end
    end
    // R2 R3 R12 R13: strobes
    chk(fl ? "R12 ale" : (m_ph == 0 ? "R13 ale" : "R2 ale"), 24'(ale), 24'(m_ph == 1));
    chk(fl ? "R12 rd" : "R3 rd", 24'(rd), 24'(m_ph == 3 && !m_we));
    chk(fl ? "R12 wr" : "R3 wr", 24'(wr), 24'(m_ph == 3 && m_we));
    // R8 R10 R13: enables
    chk(fl ? "R10 oe" : (m_ph == 0 ? "R13 oe" : "R8 oe"), 24'(ad_oe), 24'(e_oe));
    // R4 R5 R6 R7 R10: pin values where driven
    chk(fl ? "R10 pins" : (m_ph == 1 ? (m_wide ? "R6 pins" : "R4 pins")
                                     : (m_wide ? "R7 pins" : "R5 pins")),
        24'(ad_out & e_oe), 24'(e_ad & e_oe));
    // R1 R12: ready pulse
    chk(flag_en ? "R12 ready" : "R1 ready", 24'(ready), 24'(m_rdy));
    // R9: read data on ready
    if (m_rdy && !m_we) chk("R9 rdata", 24'(rdata), 24'(m_rdata));
    // R11: flag inputs
    chk("R11 flag_in", 24'(flag_in), 24'({ad_in[7:0], ad_in[15:8]}));
  end

  task automatic access(input bit w, input bit wd, input logic [23:0] a,
                        input logic [15:0] d, input logic [15:0] pins);
    @(negedge clk);
    we = w; wide = wd; addr = a; wdata = d; ad_in = pins; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (70) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R6 R7: word write, minimal timing
    t_a = 1; t_s = 1; t_t = 1; t_h = 1;
    access(1, 1, 24'h123456, 16'hBEEF, 16'h0000);
    // R4 R5: byte write, longer phases
    t_a = 2; t_s = 3; t_t = 1; t_h = 2;
    access(1, 0, 24'hABCDEF, 16'h005A, 16'h0000);
    // R2 R9: word read, zero lengths count as one
    t_a = 0; t_s = 0; t_t = 2; t_h = 0;
    access(0, 1, 24'h00F00D, 16'h0000, 16'hC3A5);
    // R8 R9: byte read, upper half keeps address
    t_a = 3; t_s = 1; t_t = 4; t_h = 1;
    access(0, 0, 24'h9A7E3C, 16'h0000, 16'h77E1);
    // R1: back-to-back requests with req held high
    t_a = 1; t_s = 2; t_t = 2; t_h = 1;
    @(negedge clk);
    we = 1; wide = 1; addr = 24'h00ACE1; wdata = 16'h1357; req = 1'b1;
    repeat (14) @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    // R10 R11 R12: flag mode, requests ignored
    flag_en = 1'b1; flag_out = 16'hA55A; flag_dir = 16'h0F0F; ad_in = 16'h1234;
    we = 0; wide = 0; req = 1'b1;
    repeat (10) @(negedge clk);
    flag_dir = 16'hF0C3; flag_out = 16'h3C96; ad_in = 16'hFE01;
    repeat (10) @(negedge clk);
    req = 1'b0; flag_en = 1'b0;
    repeat (3) @(negedge clk);
    // R13 R1: normal access after leaving flag mode
    access(0, 1, 24'h004242, 16'h0000, 16'h8001);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule